// File: doc/BRIEF.md
# Quality-Gated Frequency Reference Selector

This block picks one active frequency reference out of several candidate inputs. Each input reports a loss-of-signal flag, a loss-of-lock flag and a 4-bit quality code. An input can be chosen only when it is healthy and its quality code meets a programmable threshold. Among those inputs, a configured priority decides which one is chosen.

Faults on the active input are debounced by a holdoff window. A return to a recovered better input waits for a wait-to-restore window and happens only when revertive mode is on. When no alternative is usable, the block runs a holdover, reacquire and locked sequence. A manual request moves the selection to a chosen input under the same timing rules. An auto-switch disable pins the selection to one forced input.

The block drives the selected input index, the control state, the reason for the last switch, and a one-cycle pulse that marks each change of selection. It sits between the per-port health monitors and the clock multiplexer and loop controller.

Top module: `ref_sel_ctrl`

## Requirements
- R1: An input is usable when its loss-of-signal and loss-of-lock flags are both low and its quality code is numerically less than or equal to `ql_gate_i`. A lower code means better quality, and a code equal to the gate is usable. An unusable input is never selected, whatever its priority.
- R2: Among usable inputs, the one with the smallest priority value is chosen. When priority values tie, the lowest input index is chosen.
- R3: A fault on the active input in the locked state causes a switch only after it has been present on more than `holdoff_i` consecutive clock edges. A fault that clears sooner leaves the selection and state unchanged.
- R4: `reason_o` is 0 after reset and is updated at each fault or manual switch. The codes are: 1 for loss of signal, 2 for quality below the gate, 3 for manual, 4 for internal fault (loss of lock). When several faults are present, loss of signal ranks above loss of lock, and loss of lock ranks above quality.
- R5: With `revert_en_i` low, the block stays on a working input even when a better input has recovered.
- R6: With `revert_en_i` high, the block moves in the locked state to an input of strictly smaller priority value. That input must have been usable for more than `wtr_i` consecutive cycles. The reason code is left unchanged by such a return.
- R7: A manual request takes effect in the locked state when `man_req_i` has been held for more than `holdoff_i` cycles and the target has been usable for more than `wtr_i` cycles. The switch reports reason 3. While the request is held, revertive return is suppressed.
- R8: `state_o` encodes 0 as LOCKED, 1 as HOLDOVER and 2 as REACQUIRE. Reset gives HOLDOVER, input 0 and reason 0. When a debounced fault finds no usable alternative, the state goes to HOLDOVER and the selection is kept.
- R9: From HOLDOVER, the first cycle in which any allowed input is usable moves the state to REACQUIRE, with the best usable input selected.
- R10: REACQUIRE goes to LOCKED only after the selected input has been usable for more than `settle_i` consecutive cycles. Any unusable cycle restarts the count.
- R11: With `auto_dis_i` high, only input `force_sel_i` may be selected. If another input is selected, the block moves to the forced input at once, enters REACQUIRE and reports reason 3. A fault on the forced input leads to HOLDOVER, not to a different input.
- R12: `switch_o` is high for exactly the cycles in which `sel_o` takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| los_i | input | N_IN | Loss-of-signal flag per input |
| lol_i | input | N_IN | Loss-of-lock flag per input |
| ql_i | input | N_IN*QL_W | Quality code per input, input 0 in the low bits |
| prio_i | input | N_IN*PRIO_W | Priority per input, smaller is preferred |
| ql_gate_i | input | QL_W | Worst quality code still accepted |
| holdoff_i | input | TMR_W | Fault and manual debounce length in cycles |
| wtr_i | input | TMR_W | Wait-to-restore length in cycles |
| settle_i | input | TMR_W | Reacquire settling length in cycles |
| revert_en_i | input | 1 | Enables revertive return |
| auto_dis_i | input | 1 | Pins selection to the forced input |
| force_sel_i | input | IDX_W | Forced input index |
| man_req_i | input | 1 | Manual switch request, level |
| man_sel_i | input | IDX_W | Manual target index |
| sel_o | output | IDX_W | Selected input index |
| state_o | output | 2 | Control state |
| reason_o | output | 3 | Reason for the last switch |
| switch_o | output | 1 | One-cycle pulse on selection change |

## Verification
The auto-switch disable and the manual request can act in the same cycle, because one is released while the other is raised. The bench drops the manual request and raises the disable on one clock edge while a third input is active. It checks that the forced input wins, that the state becomes REACQUIRE and that reason 3 is reported. A second collision lies between a selection change and the switch pulse. A monitor compares the two on every cycle of the whole run, including state changes where the index stays the same and no pulse may appear.

// File: rtl/ref_sel_pkg.sv
`timescale 1ns/1ps
package ref_sel_pkg;
  typedef enum logic [1:0] {
    ST_LOCKED   = 2'd0,
    ST_HOLDOVER = 2'd1,
    ST_REACQ    = 2'd2
  } ref_state_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_LOS      = 3'd1,
    RSN_QL       = 3'd2,
    RSN_MANUAL   = 3'd3,
    RSN_INTERNAL = 3'd4
  } ref_reason_e;
endpackage

// File: rtl/ref_qualify.sv
`timescale 1ns/1ps
module ref_qualify #(
  parameter int N_IN  = 4,
  parameter int QL_W  = 4,
  parameter int TMR_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        lol_i,
  input  logic [N_IN*QL_W-1:0]   ql_i,
  input  logic [QL_W-1:0]        ql_gate_i,
  input  logic [TMR_W-1:0]       wtr_i,
  output logic [N_IN-1:0]        good_o,
  output logic [N_IN-1:0]        stable_o
);
  for (genvar i = 0; i < N_IN; i++) begin : g_in
    logic [TMR_W-1:0] run_q;

    assign good_o[i]   = !los_i[i] && !lol_i[i] && (ql_i[i*QL_W +: QL_W] <= ql_gate_i);
    assign stable_o[i] = run_q >= wtr_i;

    // good-run length, stops at the restore window
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             run_q <= '0;
      else if (!good_o[i])     run_q <= '0;
      else if (run_q < wtr_i)  run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/ref_pick.sv
`timescale 1ns/1ps
module ref_pick #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = 2
) (
  input  logic [N_IN-1:0]        mask_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic                   vld_o,
  output logic [IDX_W-1:0]       idx_o
);
  logic [PRIO_W-1:0] best;

  // strict compare keeps the lower index on ties
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    best  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (mask_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] < best)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
        best  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/ref_sel_fsm.sv
`timescale 1ns/1ps
module ref_sel_fsm
  import ref_sel_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 2,
  parameter int TMR_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        good_i,
  input  logic [N_IN-1:0]        stable_i,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        lol_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic [TMR_W-1:0]       holdoff_i,
  input  logic [TMR_W-1:0]       settle_i,
  input  logic                   revert_en_i,
  input  logic                   auto_dis_i,
  input  logic [IDX_W-1:0]       force_sel_i,
  input  logic                   man_req_i,
  input  logic [IDX_W-1:0]       man_sel_i,
  output logic [IDX_W-1:0]       sel_o,
  output ref_state_e             state_o,
  output ref_reason_e            reason_o,
  output logic                   switch_o
);
  ref_state_e        state_q;
  ref_reason_e       reason_q, fault_rsn;
  logic [IDX_W-1:0]  sel_q;
  logic              switch_q;
  logic [TMR_W-1:0]  hold_cnt, settle_cnt, man_cnt;

  logic [N_IN-1:0]   allow, self_m, better, fail_m, any_m, rev_m;
  logic [PRIO_W-1:0] cur_prio;
  logic              cur_good, man_ok;
  logic              fail_vld, any_vld, rev_vld;
  logic [IDX_W-1:0]  fail_idx, any_idx, rev_idx;

  always_comb begin
    allow    = auto_dis_i ? (N_IN'(1) << force_sel_i) : {N_IN{1'b1}};
    self_m   = N_IN'(1) << sel_q;
    cur_prio = prio_i[int'(sel_q)*PRIO_W +: PRIO_W];
    for (int i = 0; i < N_IN; i++) better[i] = prio_i[i*PRIO_W +: PRIO_W] < cur_prio;
    fail_m   = good_i & allow & ~self_m;
    any_m    = good_i & allow;
    rev_m    = good_i & stable_i & allow & better;
    cur_good = good_i[sel_q];
    man_ok   = (man_sel_i != sel_q) && good_i[man_sel_i] && stable_i[man_sel_i];
    if (los_i[sel_q])      fault_rsn = RSN_LOS;
    else if (lol_i[sel_q]) fault_rsn = RSN_INTERNAL;
    else                   fault_rsn = RSN_QL;
  end

  ref_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_fail (
    .mask_i(fail_m), .prio_i(prio_i), .vld_o(fail_vld), .idx_o(fail_idx));
  ref_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_any (
    .mask_i(any_m), .prio_i(prio_i), .vld_o(any_vld), .idx_o(any_idx));
  ref_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick_rev (
    .mask_i(rev_m), .prio_i(prio_i), .vld_o(rev_vld), .idx_o(rev_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HOLDOVER;
      reason_q   <= RSN_NONE;
      sel_q      <= '0;
      switch_q   <= 1'b0;
      hold_cnt   <= '0;
      settle_cnt <= '0;
      man_cnt    <= '0;
    end else begin
      switch_q <= 1'b0;
      unique case (state_q)
        ST_LOCKED: begin
          if (auto_dis_i && sel_q != force_sel_i) begin
            sel_q      <= force_sel_i;
            switch_q   <= 1'b1;
            reason_q   <= RSN_MANUAL;
            state_q    <= ST_REACQ;
            settle_cnt <= '0;
            hold_cnt   <= '0;
            man_cnt    <= '0;
          end else if (!cur_good) begin
            man_cnt <= '0;
            if (hold_cnt >= holdoff_i) begin
              hold_cnt <= '0;
              reason_q <= fault_rsn;
              if (fail_vld) begin
                sel_q    <= fail_idx;
                switch_q <= 1'b1;
              end else begin
                state_q  <= ST_HOLDOVER;
              end
            end else begin
              hold_cnt <= hold_cnt + 1'b1;
            end
          end else begin
            hold_cnt <= '0;
            if (man_req_i && !auto_dis_i) begin
              if (!man_ok) begin
                man_cnt <= '0;
              end else if (man_cnt >= holdoff_i) begin
                man_cnt  <= '0;
                sel_q    <= man_sel_i;
                switch_q <= 1'b1;
                reason_q <= RSN_MANUAL;
              end else begin
                man_cnt <= man_cnt + 1'b1;
              end
            end else begin
              man_cnt <= '0;
              if (revert_en_i && rev_vld && !auto_dis_i) begin
                sel_q    <= rev_idx;
                switch_q <= 1'b1;
              end
            end
          end
        end
        ST_HOLDOVER: begin
          if (any_vld) begin
            state_q    <= ST_REACQ;
            settle_cnt <= '0;
            sel_q      <= any_idx;
            switch_q   <= (any_idx != sel_q);
          end
        end
        ST_REACQ: begin
          if (auto_dis_i && sel_q != force_sel_i) begin
            sel_q      <= force_sel_i;
            switch_q   <= 1'b1;
            reason_q   <= RSN_MANUAL;
            settle_cnt <= '0;
          end else if (!cur_good) begin
            settle_cnt <= '0;
          end else if (settle_cnt >= settle_i) begin
            state_q    <= ST_LOCKED;
            settle_cnt <= '0;
            hold_cnt   <= '0;
            man_cnt    <= '0;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        default: state_q <= ST_HOLDOVER;
      endcase
    end
  end

  assign sel_o    = sel_q;
  assign state_o  = state_q;
  assign reason_o = reason_q;
  assign switch_o = switch_q;

  assert_fail_pick_usable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_vld |-> good_i[fail_idx]);
  assert_holdoff_keeps_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && !cur_good && hold_cnt < holdoff_i && !auto_dis_i) |=> $stable(sel_q));
  assert_holdover_waits_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLDOVER && !any_vld) |=> (state_q == ST_HOLDOVER && $stable(sel_q)));
  assert_settle_restart_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REACQ && !cur_good) |=> state_q == ST_REACQ);
  assert_pulse_on_change_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_q |-> sel_q != $past(sel_q));
endmodule

// File: rtl/ref_sel_ctrl.sv
`timescale 1ns/1ps
module ref_sel_ctrl
  import ref_sel_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int QL_W   = 4,
  parameter int PRIO_W = 2,
  parameter int TMR_W  = 16,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        lol_i,
  input  logic [N_IN*QL_W-1:0]   ql_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic [QL_W-1:0]        ql_gate_i,
  input  logic [TMR_W-1:0]       holdoff_i,
  input  logic [TMR_W-1:0]       wtr_i,
  input  logic [TMR_W-1:0]       settle_i,
  input  logic                   revert_en_i,
  input  logic                   auto_dis_i,
  input  logic [IDX_W-1:0]       force_sel_i,
  input  logic                   man_req_i,
  input  logic [IDX_W-1:0]       man_sel_i,
  output logic [IDX_W-1:0]       sel_o,
  output logic [1:0]             state_o,
  output logic [2:0]             reason_o,
  output logic                   switch_o
);
  logic [N_IN-1:0] good, stable;
  ref_state_e      state;
  ref_reason_e     reason;

  ref_qualify #(.N_IN(N_IN), .QL_W(QL_W), .TMR_W(TMR_W)) u_qualify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .los_i     (los_i),
    .lol_i     (lol_i),
    .ql_i      (ql_i),
    .ql_gate_i (ql_gate_i),
    .wtr_i     (wtr_i),
    .good_o    (good),
    .stable_o  (stable)
  );

  ref_sel_fsm #(.N_IN(N_IN), .PRIO_W(PRIO_W), .TMR_W(TMR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .good_i      (good),
    .stable_i    (stable),
    .los_i       (los_i),
    .lol_i       (lol_i),
    .prio_i      (prio_i),
    .holdoff_i   (holdoff_i),
    .settle_i    (settle_i),
    .revert_en_i (revert_en_i),
    .auto_dis_i  (auto_dis_i),
    .force_sel_i (force_sel_i),
    .man_req_i   (man_req_i),
    .man_sel_i   (man_sel_i),
    .sel_o       (sel_o),
    .state_o     (state),
    .reason_o    (reason),
    .switch_o    (switch_o)
  );

  assign state_o  = state;
  assign reason_o = reason;
endmodule

// File: tb/ref_sel_ctrl_tb.sv
`timescale 1ns/1ps
module ref_sel_ctrl_tb;
  localparam int N_IN = 4, QL_W = 4, PRIO_W = 2, TMR_W = 16, IDX_W = 2;

  typedef struct packed {
    logic [3:0]  los;
    logic [3:0]  lol;
    logic [15:0] ql;
    logic        rev;
    logic        adis;
    logic [1:0]  fsel;
    logic        mreq;
    logic [1:0]  msel;
    logic [7:0]  cyc;
    logic [1:0]  esel;
    logic [1:0]  est;
    logic [2:0]  ersn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  // prio: in0=0, in1=1, in2=1, in3=3; gate 8; holdoff 4; wtr 6; settle 5
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd3,  2'd0, 2'd2, 3'd0, 8'd9 },  // R9 leave holdover
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd10, 2'd0, 2'd0, 3'd0, 8'd10},  // R10 settled
    '{4'b0001, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd3,  2'd0, 2'd0, 3'd0, 8'd3 },  // R3 short LOS
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd2,  2'd0, 2'd0, 3'd0, 8'd3 },  // R3 ignored
    '{4'b0000, 4'b0000, 16'h222C, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd8,  2'd1, 2'd0, 3'd2, 8'd2 },  // R2 tie -> in1
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd20, 2'd1, 2'd0, 3'd2, 8'd5 },  // R5 no revert
    '{4'b0000, 4'b0000, 16'h2222, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd3,  2'd0, 2'd0, 3'd2, 8'd6 },  // R6 revert
    '{4'b0000, 4'b0001, 16'h2222, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd8,  2'd1, 2'd0, 3'd4, 8'd4 },  // R4 internal
    '{4'b0000, 4'b0000, 16'h2222, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd4,  2'd1, 2'd0, 3'd4, 8'd6 },  // R6 inside WTR
    '{4'b0000, 4'b0000, 16'h2222, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd6,  2'd0, 2'd0, 3'd4, 8'd6 },  // R6 after WTR
    '{4'b0000, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd8,  2'd1, 2'd0, 3'd2, 8'd1 },  // R1 gate edge
    '{4'b0010, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd8,  2'd2, 2'd0, 3'd1, 8'd4 },  // R4 LOS
    '{4'b0000, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd15, 2'd2, 2'd0, 3'd1, 8'd6 },  // R6 equal prio
    '{4'b1110, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd8,  2'd2, 2'd1, 3'd1, 8'd8 },  // R8 holdover
    '{4'b0110, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd3,  2'd3, 2'd2, 3'd1, 8'd9 },  // R9 reacquire
    '{4'b0110, 4'b1000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd3,  2'd3, 2'd2, 3'd1, 8'd10},  // R10 bad
    '{4'b0110, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd4,  2'd3, 2'd2, 3'd1, 8'd10},  // R10 restart
    '{4'b0110, 4'b0000, 16'h2289, 1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 8'd4,  2'd3, 2'd0, 3'd1, 8'd10},  // R10 locked
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 8'd10, 2'd3, 2'd0, 3'd1, 8'd5 },  // R5 stay
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 8'd3,  2'd3, 2'd0, 3'd1, 8'd7 },  // R7 pending
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b0, 2'd0, 1'b1, 2'd2, 8'd4,  2'd2, 2'd0, 3'd3, 8'd7 },  // R7 taken
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 8'd2,  2'd1, 2'd2, 3'd3, 8'd11},  // R11 forced
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 8'd10, 2'd1, 2'd0, 3'd3, 8'd11},  // R11 settles
    '{4'b0010, 4'b0000, 16'h2222, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 8'd8,  2'd1, 2'd1, 3'd1, 8'd11},  // R11 no escape
    '{4'b0000, 4'b0000, 16'h2222, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 8'd3,  2'd1, 2'd2, 3'd1, 8'd11}   // R11 back
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N_IN-1:0] los_i = '0, lol_i = '0;
  logic [N_IN*QL_W-1:0] ql_i = 16'h2222;
  logic [N_IN*PRIO_W-1:0] prio_i = {2'd3, 2'd1, 2'd1, 2'd0};
  logic [QL_W-1:0] ql_gate_i = 4'd8;
  logic [TMR_W-1:0] holdoff_i = 16'd4, wtr_i = 16'd6, settle_i = 16'd5;
  logic revert_en_i = 1'b0, auto_dis_i = 1'b0, man_req_i = 1'b0;
  logic [IDX_W-1:0] force_sel_i = '0, man_sel_i = '0;
  logic [IDX_W-1:0] sel_o;
  logic [1:0] state_o;
  logic [2:0] reason_o;
  logic switch_o;

  int n_chk = 0, n_fail = 0, pulse_err = 0, pulse_cnt = 0;
  bit done = 1'b0;
  logic [IDX_W-1:0] prev_sel = '0;

  always #2.5 clk_i = ~clk_i;

  ref_sel_ctrl #(.N_IN(N_IN), .QL_W(QL_W), .PRIO_W(PRIO_W), .TMR_W(TMR_W)) u_dut (
    .clk_i, .rst_ni, .los_i, .lol_i, .ql_i, .prio_i, .ql_gate_i, .holdoff_i, .wtr_i,
    .settle_i, .revert_en_i, .auto_dis_i, .force_sel_i, .man_req_i, .man_sel_i,
    .sel_o, .state_o, .reason_o, .switch_o);

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R12: pulse must coincide with every index change and nothing else
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (switch_o !== (sel_o != prev_sel)) pulse_err++;
      if (switch_o) pulse_cnt++;
    end
    prev_sel <= sel_o;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8", "reset state", int'(state_o), 1);
    check("R8", "reset sel", int'(sel_o), 0);
    check("R4", "reset reason", int'(reason_o), 0);
    check("R12", "reset pulse", int'(switch_o), 0);
    rst_ni = 1'b1;
    for (int k = 0; k < NV; k++) begin
      los_i       = VECS[k].los;
      lol_i       = VECS[k].lol;
      ql_i        = VECS[k].ql;
      revert_en_i = VECS[k].rev;
      auto_dis_i  = VECS[k].adis;
      force_sel_i = VECS[k].fsel;
      man_req_i   = VECS[k].mreq;
      man_sel_i   = VECS[k].msel;
      repeat (int'(VECS[k].cyc)) @(posedge clk_i);
      @(negedge clk_i);
      check($sformatf("R%0d v%0d", VECS[k].req, k), "sel", int'(sel_o), int'(VECS[k].esel));
      check($sformatf("R%0d v%0d", VECS[k].req, k), "state", int'(state_o), int'(VECS[k].est));
      check($sformatf("R%0d v%0d", VECS[k].req, k), "reason", int'(reason_o), int'(VECS[k].ersn));
    end
    // R12 whole-run pulse audit
    check("R12", "pulse mismatches", pulse_err, 0);
    check("R12", "pulses seen >= 8", int'(pulse_cnt >= 8), 1);
    // R8 asynchronous reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R8", "re-reset state", int'(state_o), 1);
    check("R8", "re-reset sel", int'(sel_o), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule